// File: doc/BRIEF.md
# Serial Command Word Master

This engine moves one command word to a serial slave controller over three wires. It drives a clock line and an outgoing data line, and it reads an incoming data line. While the command goes out, the engine collects a reply word of the same width. Each exchange opens with a start marker and closes with a stop marker. Both markers are made by moving the outgoing data line while the clock line is high. Every pin movement is followed by a hold of `STEP` clock cycles, so the slave sees a slow, evenly paced waveform.

A client places a word on `cmd` and pulses `start`. `busy` stays high for the whole exchange. When the stop marker is complete, `done` pulses for one cycle and `reply` presents the collected word. The top two bits of `reply` are overwritten with the top two bits of the command, which form the page field. This lets the reply be matched to the page it answers.

Top module: `serial_cmd_master`

## Requirements
- R1: After a synchronous active-high reset, applied in idle or in the middle of a transfer, `ser_clk` = 1, `ser_dout` = 1, `busy` = 0 and `done` = 0. These line levels hold whenever the engine is idle.
- R2: The first pin movement after `start` is accepted lowers `ser_dout` while `ser_clk` stays high. The next movement lowers `ser_clk` with `ser_dout` still low.
- R3: The command word goes out most significant bit first, one bit per clock pulse. The bit is placed on `ser_dout` before `ser_clk` rises, and `ser_dout` does not move while `ser_clk` is high inside a transfer, except at the stop marker.
- R4: `ser_din` is sampled once per bit, after the clock falls. The first sample lands in the reply MSB and the last sample lands in bit 0, so `reply[29:0]` equals the samples of bits 2 through 31 in that order.
- R5: `reply[31:30]` equals `cmd[31:30]` as captured when the transfer was accepted.
- R6: The transfer closes by raising `ser_clk` with `ser_dout` low. One step later, `ser_dout` rises while `ser_clk` stays high. This comes after exactly W clock pulses.
- R7: Successive pin movements are at least `STEP` cycles apart. `busy` stays high for exactly (3*W+4)*STEP cycles per transfer.
- R8: A `start` pulse while `busy` is high has no effect. The transfer in flight keeps its command, its length and its page bits.
- R9: `done` is high for exactly one cycle, with `busy` low, at the end of the stop marker. `reply` keeps its value until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a transfer when idle |
| cmd | input | W | Command word, captured when start is accepted |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse when the transfer completes |
| reply | output | W | Collected reply with page bits replaced |
| ser_clk | output | 1 | Serial clock to the slave |
| ser_dout | output | 1 | Serial data to the slave |
| ser_din | input | 1 | Serial data from the slave |

## Verification
The hardest situation to reach from the ports is a second `start` arriving in the middle of a running transfer while `cmd` holds a different word. The bench raises `start` forty cycles into a transfer and inverts `cmd` at the same moment. It then checks three things: the slave model still receives the original word, the busy time is unchanged, and the reply page bits come from the first command. A reset in the middle of a transfer is also forced, and the lines are checked to return high at once.

// File: rtl/serial_cmd_master.sv
module serial_cmd_master #(
  parameter int W    = 32,
  parameter int STEP = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] cmd,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] reply,
  output logic         ser_clk,
  output logic         ser_dout,
  input  logic         ser_din
);
  localparam int CW = (STEP > 1) ? $clog2(STEP) : 1;
  localparam int BW = $clog2(W);

  typedef enum logic [2:0] {
    S_IDLE, S_OPEN_D, S_OPEN_C, S_SETUP, S_HIGH, S_LOW, S_CLOSE_C, S_CLOSE_D
  } state_t;

  state_t         state, nxt;
  logic [CW-1:0]  cnt;
  logic [BW-1:0]  idx;
  logic [W-1:0]   tx, rx;
  logic [1:0]     page_q;
  logic           step_end;

  assign step_end = (cnt == CW'(STEP - 1));
  assign busy     = (state != S_IDLE);

  always_comb begin
    nxt = state;
    case (state)
      S_IDLE:    if (start)    nxt = S_OPEN_D;
      S_OPEN_D:  if (step_end) nxt = S_OPEN_C;
      S_OPEN_C:  if (step_end) nxt = S_SETUP;
      S_SETUP:   if (step_end) nxt = S_HIGH;
      S_HIGH:    if (step_end) nxt = S_LOW;
      S_LOW:     if (step_end) nxt = (idx == BW'(W - 1)) ? S_CLOSE_C : S_SETUP;
      S_CLOSE_C: if (step_end) nxt = S_CLOSE_D;
      S_CLOSE_D: if (step_end) nxt = S_IDLE;
      default:                 nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      cnt      <= '0;
      idx      <= '0;
      tx       <= '0;
      rx       <= '0;
      page_q   <= '0;
      ser_clk  <= 1'b1;
      ser_dout <= 1'b1;
      done     <= 1'b0;
      reply    <= '0;
    end else begin
      done  <= 1'b0;
      state <= nxt;
      if (busy) cnt <= step_end ? '0 : cnt + 1'b1;

      if (state == S_LOW && step_end) begin
        tx  <= {tx[W-2:0], 1'b0};
        rx  <= {rx[W-2:0], ser_din};
        idx <= idx + 1'b1;
      end

      if (state != nxt) begin
        case (nxt)
          S_OPEN_D: begin
            ser_dout <= 1'b0;
            tx       <= cmd;
            page_q   <= cmd[W-1:W-2];
            idx      <= '0;
            cnt      <= '0;
          end
          S_OPEN_C:  ser_clk  <= 1'b0;
          S_SETUP:   ser_dout <= (state == S_LOW) ? tx[W-2] : tx[W-1];
          S_HIGH:    ser_clk  <= 1'b1;
          S_LOW:     ser_clk  <= 1'b0;
          S_CLOSE_C: begin
            ser_clk  <= 1'b1;
            ser_dout <= 1'b0;
          end
          S_CLOSE_D: ser_dout <= 1'b1;
          S_IDLE: begin
            done  <= 1'b1;
            reply <= {page_q, rx[W-3:0]};
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/serial_cmd_master_chk.sv
module serial_cmd_master_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] reply,
  input logic         ser_clk,
  input logic         ser_dout,
  input logic [1:0]   page_q,
  input logic         step_end
);
  p_idle_lines_r1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (ser_clk && ser_dout));

  p_open_marker_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (ser_clk && !ser_dout));

  p_data_hold_high_r3: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && ser_clk && $past(ser_clk) && !$stable(ser_dout)) |-> ser_dout);

  p_page_bits_r5: assert property (@(posedge clk) disable iff (rst)
    done |-> (reply[W-1:W-2] == page_q));

  p_pin_pace_r7: assert property (@(posedge clk) disable iff (rst)
    ($past(busy) && !$stable({ser_clk, ser_dout})) |-> $past(step_end));

  p_busy_start_r8: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> (busy && $stable(page_q)));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_idle_r9: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
endmodule

bind serial_cmd_master serial_cmd_master_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
  .reply(reply), .ser_clk(ser_clk), .ser_dout(ser_dout),
  .page_q(page_q), .step_end(step_end)
);

// File: tb/serial_cmd_master_bench.sv
`timescale 1ns/1ps
module serial_cmd_master_bench;
  localparam int W    = 32;
  localparam int STEP = 4;
  localparam int XFER = (3 * W + 4) * STEP;
  localparam int NV   = 4;
  localparam logic [63:0] VEC [NV] = '{
    {32'hC000_0001, 32'h0000_0000},
    {32'h4A5A_F00F, 32'hFFFF_FFFF},
    {32'h8123_4567, 32'h3CA5_5AC3},
    {32'h0000_0000, 32'hBFFF_FFFE}
  };

  logic clk = 0, rst = 1, start = 0, ser_din = 0;
  logic [W-1:0] cmd = '0;
  logic busy, done, ser_clk, ser_dout;
  logic [W-1:0] reply;
  int tests = 0, fails = 0;

  always #2.5 clk = ~clk;

  serial_cmd_master #(.W(W), .STEP(STEP)) u_serial_cmd_master (
    .clk(clk), .rst(rst), .start(start), .cmd(cmd), .busy(busy), .done(done),
    .reply(reply), .ser_clk(ser_clk), .ser_dout(ser_dout), .ser_din(ser_din)
  );

  // slave model and line monitor
  logic [W-1:0] slave_word = '0, got_cmd = '0;
  logic p_clk = 1, p_dout = 1;
  bit in_frame = 0, after_open = 0, open_ok = 0, close_ok = 0, gap_bad = 0, prot_bad = 0;
  int nbits = 0, since = 0;

  always @(negedge clk) begin
    if (rst) begin
      in_frame = 0; since = 0;
    end else begin
      if (!in_frame) begin
        if (p_clk && ser_clk && p_dout && !ser_dout) begin
          in_frame = 1; nbits = 0; after_open = 1; open_ok = 0;
          close_ok = 0; gap_bad = 0; prot_bad = 0; since = 0;
        end
      end else if (ser_clk != p_clk || ser_dout != p_dout) begin
        if (since < STEP - 1) gap_bad = 1;
        if (after_open) begin
          open_ok = !ser_clk && !ser_dout; after_open = 0;
        end else if (p_clk && ser_clk && !p_dout && ser_dout) begin
          close_ok = (nbits == W); in_frame = 0;
        end else if (p_clk && ser_clk) begin
          prot_bad = 1;
        end else if (!p_clk && ser_clk && nbits < W) begin
          got_cmd = {got_cmd[W-2:0], ser_dout};
          ser_din = slave_word[W-1-nbits];
          nbits++;
        end
        since = 0;
      end else begin
        since++;
      end
    end
    p_clk = ser_clk; p_dout = ser_dout;
  end

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_xfer(input logic [W-1:0] c, input logic [W-1:0] r, input bit poke);
    int bc;
    int guard;
    logic [W-1:0] exp;
    exp = {c[W-1:W-2], r[W-3:0]};
    slave_word = r;
    @(negedge clk); cmd = c; start = 1;
    @(negedge clk); start = 0;
    bc = busy ? 1 : 0;
    guard = 0;
    forever begin
      @(negedge clk);
      guard++;
      if (done || guard > 4 * XFER) break;
      if (busy) bc++;
      if (poke && bc == 40) begin start = 1; cmd = ~c; end
      if (poke && bc == 41) start = 0;
    end
    chk(done, "R9 done seen", {31'd0, done}, 1);
    chk(!busy, "R9 busy low with done", {31'd0, busy}, 0);
    chk(open_ok, "R2 start marker", {31'd0, open_ok}, 1);
    chk(got_cmd == c && !prot_bad, "R3 command bits", got_cmd, c);
    chk(reply[W-3:0] == exp[W-3:0], "R4 reply bits", reply, exp);
    chk(reply[W-1:W-2] == c[W-1:W-2], "R5 page bits", reply, exp);
    chk(close_ok, "R6 stop marker", nbits, W);
    chk(!gap_bad, "R7 pin pacing", {31'd0, gap_bad}, 0);
    chk(bc == XFER, "R7 busy length", bc, XFER);
    if (poke) chk(bc == XFER && got_cmd == c, "R8 start ignored while busy", got_cmd, c);
    @(negedge clk);
    chk(!done, "R9 done single cycle", {31'd0, done}, 0);
    cmd = ~cmd;
    repeat (10) @(negedge clk);
    chk(reply == exp, "R9 reply held", reply, exp);
    chk(ser_clk && ser_dout, "R1 idle lines", {30'd0, ser_clk, ser_dout}, 3);
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(ser_clk && ser_dout && !busy && !done, "R1 reset state",
        {28'd0, ser_clk, ser_dout, busy, done}, 32'hC);

    for (int i = 0; i < NV; i++) run_xfer(VEC[i][63:32], VEC[i][31:0], 1'b0);

    run_xfer(32'h9876_5432, 32'h1357_9BDF, 1'b1);

    // reset in the middle of a transfer
    @(negedge clk); cmd = 32'hFFFF_0000; start = 1;
    @(negedge clk); start = 0;
    repeat (30) @(negedge clk);
    rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(ser_clk && ser_dout && !busy && !done, "R1 reset mid transfer",
        {28'd0, ser_clk, ser_dout, busy, done}, 32'hC);

    run_xfer(32'h7FFF_FFFF, 32'h8000_0001, 1'b0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule